// File: doc/BRIEF.md
# Clock Synthesizer Program Word Serializer

This block drives the two-wire programming port of a serially programmed frequency synthesizer. For a program transfer it takes the loop divider values P and Q, a 4-bit range index, a 3-bit post-divide select and a duty trim bit. It offsets P and Q into 7-bit counter codes, packs the 22-bit program word and shifts it out least significant bit first. After every third consecutive one it inserts a zero, so that the receiver's framing marker never appears inside the data.

A control transfer sends 8 control bits under the same zero-insertion rule. The 6-bit framing marker follows with no insertion, which tells the receiver to latch the control byte. The serial clock is built from the system clock. Its high and low phases are set by two count inputs that are latched when a transfer is accepted. Data changes only while the serial clock is low.

Top module: `pll_word_serializer`

## Requirements
- R1: After reset, sclk, sdata, busy, done and err are all 0.
- R2: A program transfer sends the 22-bit word {P−3 (7 bits), D, M (3 bits), Q−2 (7 bits), I (4 bits)}, with the P code in the top bits. Bit 0 goes first, so I[0] leads. M is passed unchanged, and M = k selects a post-divide of 2^k.
- R3: Within the payload, a 0 is inserted after every third consecutive 1, including when that third 1 is the last payload bit. The run count restarts at each transfer and after each inserted 0. For example, P=91, Q=33, D=1, M=1, I=0 yields 23 serial bits.
- R4: A control transfer sends the 8 control bits, bit 0 first, with the insertion rule of R3. It then sends the marker bits 0,1,1,1,1,0, never stuffed.
- R5: A program start with P outside 4..130 or Q outside 3..129 is refused. err pulses high for one cycle on the cycle after the start, and busy and sclk stay low.
- R6: Each serial bit holds sclk high for hi_cnt+1 system clock cycles.
- R7: Before each rising sclk edge, sclk is low for lo_cnt+2 system clock cycles.
- R8: sdata changes only while sclk is low. It is stable for at least one cycle before sclk rises, and stays stable throughout the high phase.
- R9: busy rises on the cycle after an accepted start. It falls on the cycle that done pulses high for exactly one cycle, after the last bit's high phase.
- R10: Start strobes that arrive while busy is high are ignored. They do not alter the stream, and they start no transfer afterwards.
- R11: If both starts are asserted in the same idle cycle, the program start takes priority and the control start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Request a program word transfer |
| ctrl_start | input | 1 | Request a control byte transfer |
| p_val | input | 8 | Feedback divider P (4..130) |
| q_val | input | 8 | Reference divider Q (3..129) |
| idx_val | input | 4 | Range index field |
| mux_val | input | 3 | Post-divide select (divide by 2^mux_val) |
| duty_val | input | 1 | Duty trim bit |
| ctrl_val | input | 8 | Control byte |
| hi_cnt | input | CNT_W | sclk high phase count |
| lo_cnt | input | CNT_W | sclk low phase count |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data to the synthesizer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| err | output | 1 | One-cycle pulse when a program start is refused |

## Verification
busy is due on the first cycle after the edge that accepts a start, and err is due on that same cycle for a refused start. The bench samples both on the falling edge that follows the strobe. The first sclk rise comes lo_cnt+2 cycles after acceptance, and the following rises come every hi_cnt+lo_cnt+3 cycles. The bench does not predict absolute edge times. It samples every cycle on the falling clock edge, measures each high and low run, and compares the widths with R6 and R7. It records sdata at each rise and holds that value against the whole high phase. done is due one cycle after the final high phase ends. The bench waits for it, then checks that busy and done are low on the next cycle and that no further transfer starts.

// File: rtl/pws_pkg.sv
// Shared constants and types for the program word serializer.
// Assumes the receiver recognises four ones in a row as its framing marker.
package pws_pkg;
    localparam int PROG_W    = 22;
    localparam int CTRL_W    = 8;
    localparam int MARK_W    = 6;
    localparam logic [MARK_W-1:0] MARK_BITS = 6'b011110;
    localparam int RUN_LIMIT = 3;
    localparam int RUN_W     = $clog2(RUN_LIMIT + 1);
    localparam int LEN_W     = $clog2(PROG_W + 1);
    localparam int MCNT_W    = $clog2(MARK_W + 1);
    localparam int DIV_W     = 8;
    localparam int CODE_W    = 7;
    localparam int IDX_W     = 4;
    localparam int MUX_W     = 3;
    localparam int P_MIN     = 4;
    localparam int P_MAX     = 130;
    localparam int Q_MIN     = 3;
    localparam int Q_MAX     = 129;
    localparam int P_OFS     = 3;
    localparam int Q_OFS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_LOW,
        ST_HIGH
    } ser_state_t;
endpackage

// File: rtl/pws_word_pack.sv
// Builds the 22-bit program word from divider values and checks their range.
// Purely combinational; assumes P and Q are unsigned binary.
module pws_word_pack
    import pws_pkg::*;
(
    input  logic [DIV_W-1:0]  p_val,
    input  logic [DIV_W-1:0]  q_val,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic [MUX_W-1:0]  mux_val,
    input  logic              duty_val,
    output logic [PROG_W-1:0] word,
    output logic              word_ok
);
    logic [CODE_W-1:0] p_code;
    logic [CODE_W-1:0] q_code;

    // Offset the divider values into counter codes and concatenate the fields.
    always_comb begin
        p_code  = p_val[CODE_W-1:0] - CODE_W'(P_OFS);
        q_code  = q_val[CODE_W-1:0] - CODE_W'(Q_OFS);
        word    = {p_code, duty_val, mux_val, q_code, idx_val};
        word_ok = (p_val >= DIV_W'(P_MIN)) && (p_val <= DIV_W'(P_MAX)) &&
                  (q_val >= DIV_W'(Q_MIN)) && (q_val <= DIV_W'(Q_MAX));
    end
endmodule

// File: rtl/pws_stuffer.sv
// Bit source for one transfer: payload LSB first with zero insertion after
// every RUN_LIMIT ones, then an optional unstuffed marker.
// Assumes adv is only raised when the caller consumes bit_o.
module pws_stuffer
    import pws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PROG_W-1:0] load_word,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              load_mark,
    input  logic              adv,
    output logic              bit_o,
    output logic              more_o
);
    logic [PROG_W-1:0] pay_sh;
    logic [LEN_W-1:0]  pay_rem;
    logic [RUN_W-1:0]  run;
    logic [MARK_W-1:0] mk_sh;
    logic [MCNT_W-1:0] mk_rem;
    logic              do_stuff;
    logic              do_pay;
    logic              do_mark;

    // Pick the next bit: pending stuff zero, then payload, then marker.
    always_comb begin
        do_stuff = (run == RUN_W'(RUN_LIMIT));
        do_pay   = !do_stuff && (pay_rem != '0);
        do_mark  = !do_stuff && (pay_rem == '0) && (mk_rem != '0);
        more_o   = do_stuff || do_pay || do_mark;
        bit_o    = do_pay ? pay_sh[0] : (do_mark ? mk_sh[0] : 1'b0);
    end

    // Advance the payload, run counter and marker state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_sh  <= '0;
            pay_rem <= '0;
            run     <= '0;
            mk_sh   <= '0;
            mk_rem  <= '0;
        end else if (load) begin
            pay_sh  <= load_word;
            pay_rem <= load_len;
            run     <= '0;
            mk_sh   <= MARK_BITS;
            mk_rem  <= load_mark ? MCNT_W'(MARK_W) : '0;
        end else if (adv) begin
            if (do_stuff) begin
                run <= '0;
            end else if (do_pay) begin
                pay_sh  <= pay_sh >> 1;
                pay_rem <= pay_rem - LEN_W'(1);
                run     <= pay_sh[0] ? run + RUN_W'(1) : '0;
            end else if (do_mark) begin
                mk_sh  <= mk_sh >> 1;
                mk_rem <= mk_rem - MCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pws_phase_timer.sv
// Down counter timing one sclk phase; zero is high once the count is spent.
// Assumes load is given on the last cycle of the previous phase.
module pws_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pll_word_serializer.sv
// Top of the serializer: accepts program or control starts, sequences bits
// through the stuffer and shapes sclk from the phase timer.
// Assumes start strobes are synchronous to clk; program start has priority.
module pll_word_serializer
    import pws_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start,
    input  logic             ctrl_start,
    input  logic [7:0]       p_val,
    input  logic [7:0]       q_val,
    input  logic [3:0]       idx_val,
    input  logic [2:0]       mux_val,
    input  logic             duty_val,
    input  logic [7:0]       ctrl_val,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             sclk,
    output logic             sdata,
    output logic             busy,
    output logic             done,
    output logic             err
);
    ser_state_t        st;
    logic [CNT_W-1:0]  hi_q;
    logic [CNT_W-1:0]  lo_q;
    logic [PROG_W-1:0] prog_word;
    logic              word_ok;
    logic              acc_prog;
    logic              acc_ctrl;
    logic              ld;
    logic [PROG_W-1:0] ld_word;
    logic [LEN_W-1:0]  ld_len;
    logic              adv;
    logic              nxt_bit;
    logic              more;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;

    pws_word_pack u_pack (
        .p_val    (p_val),
        .q_val    (q_val),
        .idx_val  (idx_val),
        .mux_val  (mux_val),
        .duty_val (duty_val),
        .word     (prog_word),
        .word_ok  (word_ok)
    );

    pws_stuffer u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_word (ld_word),
        .load_len  (ld_len),
        .load_mark (acc_ctrl),
        .adv       (adv),
        .bit_o     (nxt_bit),
        .more_o    (more)
    );

    pws_phase_timer #(.W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    // Decide acceptance, payload selection and timer reloads.
    always_comb begin
        acc_prog = (st == ST_IDLE) && prog_start && word_ok;
        acc_ctrl = (st == ST_IDLE) && !prog_start && ctrl_start;
        ld       = acc_prog || acc_ctrl;
        ld_word  = acc_prog ? prog_word : {{(PROG_W-CTRL_W){1'b0}}, ctrl_val};
        ld_len   = acc_prog ? LEN_W'(PROG_W) : LEN_W'(CTRL_W);
        adv      = (st == ST_STEP);
        tmr_load = ((st == ST_STEP) && more) || ((st == ST_LOW) && tmr_zero);
        tmr_val  = (st == ST_STEP) ? lo_q : hi_q;
    end

    // Transfer state machine driving sclk, sdata and the status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sclk  <= 1'b0;
            sdata <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (ld) begin
                        hi_q <= hi_cnt;
                        lo_q <= lo_cnt;
                        st   <= ST_STEP;
                    end else if (prog_start) begin
                        err <= 1'b1;
                    end
                end
                ST_STEP: begin
                    if (more) begin
                        sdata <= nxt_bit;
                        st    <= ST_LOW;
                    end else begin
                        sdata <= 1'b0;
                        done  <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_LOW: begin
                    if (tmr_zero) begin
                        sclk <= 1'b1;
                        st   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr_zero) begin
                        sclk <= 1'b0;
                        st   <= ST_STEP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/pws_checker.sv
// Protocol checker for the serializer's output pins, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module pws_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdata,
    input logic busy,
    input logic done,
    input logic err
);
    logic [1:0] low_run;

    // Count sampled low cycles of sclk, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_run <= '0;
        else if (sclk)             low_run <= '0;
        else if (low_run != 2'd3)  low_run <= low_run + 2'd1;
    end

    // R8
    data_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> (!sclk && !$past(sclk)));
    // R7
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (low_run >= 2'd2));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    sclk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);
    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !sclk));
endmodule

bind pll_word_serializer pws_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .sdata (sdata),
    .busy  (busy),
    .done  (done),
    .err   (err)
);

// File: tb/sim_pll_word_serializer.sv
// Sweeping bench for the serializer: expected streams computed arithmetically.
module sim_pll_word_serializer;
    localparam int CW = 8;
    localparam logic [5:0] MK = 6'b011110;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, ctrl_start = 1'b0;
    logic [7:0]    p_val = '0, q_val = '0, ctrl_val = '0;
    logic [3:0]    idx_val = '0;
    logic [2:0]    mux_val = '0;
    logic          duty_val = 1'b0;
    logic [CW-1:0] hi_cnt = '0, lo_cnt = '0;
    logic          sclk, sdata, busy, done, err;

    pll_word_serializer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .ctrl_start(ctrl_start),
        .p_val(p_val), .q_val(q_val), .idx_val(idx_val), .mux_val(mux_val),
        .duty_val(duty_val), .ctrl_val(ctrl_val), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
        .sclk(sclk), .sdata(sdata), .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [63:0] exp_bits;
    int exp_len;
    int obs_len;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected serial stream: payload LSB first with zero insertion, then marker.
    task automatic build_exp(input logic [21:0] pay, input int plen, input bit mark);
        int run = 0;
        exp_len  = 0;
        exp_bits = '0;
        for (int k = 0; k < plen; k++) begin
            exp_bits[exp_len] = pay[k];
            exp_len++;
            if (pay[k]) begin
                run++;
                if (run == 3) begin
                    exp_bits[exp_len] = 1'b0;
                    exp_len++;
                    run = 0;
                end
            end else begin
                run = 0;
            end
        end
        if (mark) begin
            for (int k = 0; k < 6; k++) begin
                exp_bits[exp_len] = MK[k];
                exp_len++;
            end
        end
    endtask

    task automatic pulse(input bit pg, input bit ct);
        @(negedge clk);
        prog_start = pg;
        ctrl_start = ct;
        @(negedge clk);
        prog_start = 1'b0;
        ctrl_start = 1'b0;
    endtask

    // Observe one transfer, measuring phases and capturing bits at sclk rises.
    task automatic watch(input string req, input int hi, input int lo, input bit poke);
        logic [63:0] ob = '0;
        int ol = 0, lrun = 1, hrun = 0, hbad = 0, lbad = 0, sbad = 0, guard = 0;
        bit prev = 1'b0, got_done = 1'b0, busy_at_done = 1'b1;
        logic pd = sdata;
        check(busy === 1'b1, "R9", "busy after start", longint'(busy), 1);
        while (!got_done && guard < 6000) begin
            @(negedge clk);
            guard++;
            prog_start = poke && (guard == 5);
            ctrl_start = poke && (guard == 5);
            if (sclk) begin
                if (!prev) begin
                    if (lrun != lo + 2) lbad++;
                    if (pd !== sdata) sbad++;
                    if (ol < 64) ob[ol] = sdata;
                    ol++;
                    hrun = 1;
                end else begin
                    hrun++;
                    if (ol > 0 && ol <= 64 && sdata !== ob[ol-1]) sbad++;
                end
            end else begin
                if (prev) begin
                    if (hrun != hi + 1) hbad++;
                    lrun = 1;
                end else begin
                    lrun++;
                end
            end
            prev = sclk;
            pd = sdata;
            if (done) begin
                got_done = 1'b1;
                busy_at_done = busy;
            end
        end
        prog_start = 1'b0;
        ctrl_start = 1'b0;
        obs_len = ol;
        check(got_done, "R9", "done seen", longint'(got_done), 1);
        check(busy_at_done === 1'b0, "R9", "busy low with done", longint'(busy_at_done), 0);
        check(ol == exp_len, req, "bit count", ol, exp_len);
        check(ob === exp_bits, req, "stream", ob, exp_bits);
        check(hbad == 0, "R6", "high phase width errors", hbad, 0);
        check(lbad == 0, "R7", "low phase width errors", lbad, 0);
        check(sbad == 0, "R8", "data stability errors", sbad, 0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9", "done single pulse, idle",
              longint'({done, busy}), 0);
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            check(busy === 1'b0 && sclk === 1'b0, "R10", "no transfer from ignored start",
                  longint'({busy, sclk}), 0);
        end
    endtask

    task automatic prog_xfer(input int p, input int q, input int i, input int m,
                             input bit d, input int hi, input int lo, input bit poke);
        logic [6:0] pe = 7'(p - 3);
        logic [6:0] qe = 7'(q - 2);
        p_val = 8'(p); q_val = 8'(q); idx_val = 4'(i); mux_val = 3'(m); duty_val = d;
        hi_cnt = CW'(hi); lo_cnt = CW'(lo);
        build_exp({pe, d, 3'(m), qe, 4'(i)}, 22, 1'b0);
        pulse(1'b1, 1'b0);
        watch("R2/R3", hi, lo, poke);
    endtask

    task automatic ctrl_xfer(input int c, input int hi, input int lo);
        ctrl_val = 8'(c);
        hi_cnt = CW'(hi); lo_cnt = CW'(lo);
        build_exp({14'd0, 8'(c)}, 8, 1'b1);
        pulse(1'b0, 1'b1);
        watch("R4", hi, lo, 1'b0);
    endtask

    task automatic bad_prog(input int p, input int q);
        p_val = 8'(p); q_val = 8'(q);
        pulse(1'b1, 1'b0);
        check(err === 1'b1 && busy === 1'b0, "R5", "refused start", longint'({err, busy}), 2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(err === 1'b0 && busy === 1'b0 && sclk === 1'b0, "R5", "stays idle",
                  longint'({err, busy, sclk}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sclk === 0 && sdata === 0 && busy === 0 && done === 0 && err === 0,
              "R1", "reset outputs", longint'({sclk, sdata, busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: worked example grows to 23 bits
        prog_xfer(91, 33, 0, 1, 1'b1, 0, 0, 1'b0);
        check(obs_len == 23, "R3", "example length", obs_len, 23);

        // R2: P sweep
        for (int p = 4; p <= 130; p++)
            prog_xfer(p, 3 + ((p * 7) % 127), p % 16, p % 8, p[0], 0, 0, 1'b0);
        // R2: Q sweep
        for (int q = 3; q <= 129; q++)
            prog_xfer(4 + ((q * 5) % 127), q, (q * 3) % 16, q % 8, q[1], 0, 0, 1'b0);
        // R6 R7: phase widths
        prog_xfer(130, 129, 15, 7, 1'b1, 3, 1, 1'b0);
        prog_xfer(4, 3, 0, 0, 1'b0, 0, 5, 1'b0);
        prog_xfer(57, 90, 9, 4, 1'b1, 7, 7, 1'b0);
        // R4: all control bytes
        for (int c = 0; c < 256; c++) ctrl_xfer(c, 0, 0);
        ctrl_xfer(8'hFF, 2, 3);
        ctrl_xfer(8'hE0, 5, 0);

        // R5: out of range refusals
        bad_prog(3, 10);
        bad_prog(131, 10);
        bad_prog(0, 10);
        bad_prog(50, 2);
        bad_prog(50, 130);
        bad_prog(255, 255);

        // R10: starts during a transfer are ignored
        prog_xfer(100, 40, 6, 3, 1'b1, 1, 1, 1'b1);

        // R11: both starts together, program wins
        p_val = 8'd77; q_val = 8'd20; idx_val = 4'd5; mux_val = 3'd2; duty_val = 1'b1;
        ctrl_val = 8'hA5; hi_cnt = '0; lo_cnt = '0;
        build_exp({7'(77 - 3), 1'b1, 3'd2, 7'(20 - 2), 4'd5}, 22, 1'b0);
        pulse(1'b1, 1'b1);
        watch("R11", 0, 0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #3_900_000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule